// File: doc/BRIEF.md
# TDD Frame Mode Classifier

This block watches a cleaned, masked envelope bit that is high during the downlink part of each time-division duplex frame. It counts microsecond ticks while the envelope is high. When the envelope falls, the count is the length of that frame's high period. The block compares each length with the one before it. Once a run of frames agrees, it maps the length onto one of three legal downlink:uplink symbol splits. These are 30:12, 27:15 and 24:18 in a 42-symbol frame of 115.2 µs symbols.

The legal high periods are 3539 µs, 3193 µs and 2848 µs. Each is the downlink time plus half of each switching gap. A run of stable lengths that matches none of these is refused. This can happen when overlapping base-station signals are received. When no frame end arrives for a long time, the block drops its mode and raises a loss flag. Downstream frame-timing logic takes the committed mode and the one-clock change strobe and rebuilds the switching waveform.

Top module: `tdd_mode_classifier`

## Requirements
- R1: After reset, mode is 0, and mode_valid, mode_change and sig_lost are all 0.
- R2: The measured high period is the number of clock cycles in which both env_bit and us_tick are 1, taken between two falling edges of env_bit. Cycles without a tick add nothing.
- R3: A measurement within ±TOL_US (default 8) of a mode total is given that mode's code. The codes are 1 for 3539 µs (30:12), 2 for 3193 µs (27:15) and 3 for 2848 µs (24:18). Code 0 means no mode.
- R4: A measurement more than TOL_US away from every total is given code 0. For example, 3548 gives code 0.
- R5: A code becomes the output mode only after AGREE_FRAMES (default 4) consecutive agreeing frames. After three such frames, the previous mode is still shown.
- R6: A frame agrees when it has the same code as the previous frame and its length is within TOL_US of the previous length. A frame that does not agree restarts the run at one.
- R7: A stable run of code-0 frames never changes the output mode. The mode committed before the run is kept.
- R8: mode_change is high for exactly one clock at each commit. A run that confirms the mode already shown gives no pulse.
- R9: The mode output changes only at a commit or at a loss.
- R10: If no falling edge arrives for LOSS_US ticks, sig_lost goes to 1 and mode goes to 0. The agreement run is also cleared. sig_lost returns to 0 when the next measurement completes.
- R11: mode_valid is 1 exactly when mode is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| env_bit | input | 1 | Masked envelope bit, high during downlink |
| mode | output | 2 | Committed mode: 0 none, 1 = 30:12, 2 = 27:15, 3 = 24:18 |
| mode_valid | output | 1 | A legal mode is committed |
| mode_change | output | 1 | One-clock strobe at a new commit |
| sig_lost | output | 1 | No frame end seen for LOSS_US ticks |

## Verification
The classifier is driven with runs of frames. Each run sits on a mode total, on the ±8 µs window edges, just outside a window, or at a stable illegal length. These runs separate correct window bounds from bounds that are off by one, and they separate refusal of illegal lengths from blind acceptance. Two further runs test the agreement rule. In one, the code stays the same but the lengths jump by 16 µs. In the other, a new mode starts right after a committed one. Together they show whether the run restarts correctly and whether the commit comes on the fourth frame and not the third. Missing ticks are sprinkled inside the high periods, which shows that only ticks are counted. A long silence followed by a single frame exercises the loss flag being set and then cleared.

// File: rtl/tdd_cls_pkg.sv
package tdd_cls_pkg;
    localparam int unsigned NUM_MODES = 3;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_30_12 = 2'd1,
        MODE_27_15 = 2'd2,
        MODE_24_18 = 2'd3
    } mode_e;

    // high-period totals in microseconds, index i maps to code i+1
    localparam int unsigned DEF_HI_US [NUM_MODES] = '{3539, 3193, 2848};
endpackage

// File: rtl/tdd_hi_meter.sv
module tdd_hi_meter #(
    parameter int unsigned MEAS_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              env_bit,
    output logic              fall,
    output logic [MEAS_W-1:0] meas,
    output logic              meas_vld
);
    typedef struct packed {
        logic              env;
        logic [MEAS_W-1:0] cnt;
        logic [MEAS_W-1:0] meas;
        logic              vld;
    } meter_t;

    meter_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.env = env_bit;
        st_d.vld = 1'b0;
        fall     = st_q.env & ~env_bit;
        if (fall) begin
            st_d.meas = st_q.cnt;
            st_d.vld  = 1'b1;
            st_d.cnt  = '0;
        end else if (env_bit && us_tick && (st_q.cnt != '1)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign meas     = st_q.meas;
    assign meas_vld = st_q.vld;
endmodule

// File: rtl/tdd_loss_timer.sv
module tdd_loss_timer #(
    parameter int unsigned LOSS_US = 5000000,
    localparam int unsigned LOSS_W = $clog2(LOSS_US + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic restart,
    output logic expire
);
    localparam logic [LOSS_W-1:0] LIMIT = LOSS_W'(LOSS_US);
    localparam logic [LOSS_W-1:0] LAST  = LOSS_W'(LOSS_US - 1);

    typedef struct packed {
        logic [LOSS_W-1:0] cnt;
        logic              exp;
    } timer_t;

    timer_t tm_d, tm_q;

    always_comb begin
        tm_d     = tm_q;
        tm_d.exp = 1'b0;
        if (restart) begin
            tm_d.cnt = '0;
        end else if (us_tick && (tm_q.cnt != LIMIT)) begin
            tm_d.cnt = tm_q.cnt + 1'b1;
            if (tm_q.cnt == LAST) tm_d.exp = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign expire = tm_q.exp;
endmodule

// File: rtl/tdd_mode_match.sv
module tdd_mode_match
    import tdd_cls_pkg::*;
#(
    parameter int unsigned MEAS_W = 13,
    parameter int unsigned TOL_US = 8,
    parameter int unsigned HI_US [NUM_MODES] = DEF_HI_US
) (
    input  logic [MEAS_W-1:0] meas,
    output mode_e             code
);
    logic [NUM_MODES-1:0] hit;

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_win
        localparam logic [MEAS_W-1:0] LO_B = MEAS_W'(HI_US[g] - TOL_US);
        localparam logic [MEAS_W-1:0] HI_B = MEAS_W'(HI_US[g] + TOL_US);
        assign hit[g] = (meas >= LO_B) && (meas <= HI_B);
    end

    always_comb begin
        code = MODE_NONE;
        for (int i = NUM_MODES - 1; i >= 0; i--) begin
            if (hit[i]) code = mode_e'(2'(i + 1));
        end
    end
endmodule

// File: rtl/tdd_mode_classifier.sv
module tdd_mode_classifier
    import tdd_cls_pkg::*;
#(
    parameter int unsigned MEAS_W       = 13,
    parameter int unsigned TOL_US       = 8,
    parameter int unsigned AGREE_FRAMES = 4,
    parameter int unsigned LOSS_US      = 5000000,
    parameter int unsigned HI_US [NUM_MODES] = DEF_HI_US
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       env_bit,
    output logic [1:0] mode,
    output logic       mode_valid,
    output logic       mode_change,
    output logic       sig_lost
);
    localparam int unsigned AGR_W = $clog2(AGREE_FRAMES + 1);
    localparam logic [AGR_W-1:0]  AGR_MAX = AGR_W'(AGREE_FRAMES);
    localparam logic [MEAS_W-1:0] TOL_M   = MEAS_W'(TOL_US);

    typedef struct packed {
        mode_e             mode;
        logic              valid;
        logic              change;
        logic              lost;
        logic [MEAS_W-1:0] prev;
        logic              prev_vld;
        mode_e             cand;
        logic [AGR_W-1:0]  agree;
    } cls_t;

    logic              fall_w;
    logic [MEAS_W-1:0] meas_w;
    logic              meas_vld;
    logic              expire_w;
    mode_e             code_w;
    logic [MEAS_W-1:0] diff_w;
    logic              agrees_w;
    cls_t              cs_d, cs_q;

    tdd_hi_meter #(.MEAS_W(MEAS_W)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .us_tick  (us_tick),
        .env_bit  (env_bit),
        .fall     (fall_w),
        .meas     (meas_w),
        .meas_vld (meas_vld)
    );

    tdd_loss_timer #(.LOSS_US(LOSS_US)) u_loss (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick),
        .restart (fall_w),
        .expire  (expire_w)
    );

    tdd_mode_match #(.MEAS_W(MEAS_W), .TOL_US(TOL_US), .HI_US(HI_US)) u_match (
        .meas (meas_w),
        .code (code_w)
    );

    always_comb begin
        diff_w   = (meas_w >= cs_q.prev) ? (meas_w - cs_q.prev) : (cs_q.prev - meas_w);
        agrees_w = cs_q.prev_vld && (diff_w <= TOL_M) && (code_w == cs_q.cand);

        cs_d        = cs_q;
        cs_d.change = 1'b0;
        if (expire_w) begin
            cs_d.mode     = MODE_NONE;
            cs_d.valid    = 1'b0;
            cs_d.lost     = 1'b1;
            cs_d.prev_vld = 1'b0;
            cs_d.cand     = MODE_NONE;
            cs_d.agree    = '0;
        end else if (meas_vld) begin
            cs_d.lost     = 1'b0;
            cs_d.prev     = meas_w;
            cs_d.prev_vld = 1'b1;
            if (agrees_w) begin
                if (cs_q.agree != AGR_MAX) cs_d.agree = cs_q.agree + 1'b1;
            end else begin
                cs_d.agree = AGR_W'(1);
                cs_d.cand  = code_w;
            end
            if ((cs_d.agree == AGR_MAX) && (cs_d.cand != MODE_NONE) &&
                (cs_d.cand != cs_q.mode)) begin
                cs_d.mode   = cs_d.cand;
                cs_d.valid  = 1'b1;
                cs_d.change = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q      <= '0;
            cs_q.mode <= MODE_NONE;
            cs_q.cand <= MODE_NONE;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign mode        = cs_q.mode;
    assign mode_valid  = cs_q.valid;
    assign mode_change = cs_q.change;
    assign sig_lost    = cs_q.lost;
endmodule

// File: rtl/tdd_mode_classifier_chk.sv
module tdd_mode_classifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       mode_valid,
    input logic       mode_change,
    input logic       sig_lost,
    input logic       meas_vld
);
    p_valid_iff_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid == (mode != 2'd0));

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_change |=> !mode_change);

    p_strobe_new_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_change |-> (mode != $past(mode)) && mode_valid);

    p_commit_on_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_change |-> $past(meas_vld));

    p_mode_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode) |-> (mode_change || (sig_lost && mode == 2'd0)));

    p_lost_no_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sig_lost |-> !mode_valid);
endmodule

bind tdd_mode_classifier tdd_mode_classifier_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .mode_valid  (mode_valid),
    .mode_change (mode_change),
    .sig_lost    (sig_lost),
    .meas_vld    (meas_vld)
);

// File: tb/tdd_mode_classifier_bench.sv
module tdd_mode_classifier_bench;
    localparam int LOSS = 20000;
    localparam int TOL  = 8;
    localparam int AGR  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic       env_bit = 1'b0;
    logic [1:0] mode;
    logic       mode_valid, mode_change, sig_lost;

    int checks = 0, failures = 0, strobes = 0, cyc = 0, gap_mod = 16;
    int m_mode = 0, m_strobes = 0, m_prev = 0, m_prev_vld = 0, m_cand = 0, m_agree = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tdd_mode_classifier #(.LOSS_US(LOSS)) u_tdd_mode_classifier (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .env_bit(env_bit),
        .mode(mode), .mode_valid(mode_valid), .mode_change(mode_change), .sig_lost(sig_lost)
    );

    always @(negedge clk) if (rst_n && mode_change) strobes++;

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 199000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected=<199000", cyc);
            report();
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cls(int d);
        if (d >= 3539 - TOL && d <= 3539 + TOL) return 1;
        if (d >= 3193 - TOL && d <= 3193 + TOL) return 2;
        if (d >= 2848 - TOL && d <= 2848 + TOL) return 3;
        return 0;
    endfunction

    task automatic model(int d);
        int c = cls(d);
        int df = (d > m_prev) ? d - m_prev : m_prev - d;
        if (m_prev_vld != 0 && df <= TOL && c == m_cand) begin
            if (m_agree < AGR) m_agree++;
        end else begin
            m_agree = 1;
            m_cand  = c;
        end
        m_prev = d;
        m_prev_vld = 1;
        if (m_agree == AGR && m_cand != 0 && m_cand != m_mode) begin
            m_mode = m_cand;
            m_strobes++;
        end
    endtask

    task automatic cyc_drive(bit e);
        if (($urandom % gap_mod) == 0) begin
            env_bit = e; us_tick = 1'b0; @(negedge clk);
        end
        env_bit = e; us_tick = 1'b1; @(negedge clk);
    endtask

    task automatic frame(int hi, string req);
        for (int i = 0; i < hi; i++) cyc_drive(1'b1);
        for (int i = 0; i < 50; i++) cyc_drive(1'b0);
        model(hi);
        check(req, int'(mode), m_mode);
        check({req, "/R11 valid"}, int'(mode_valid), int'(m_mode != 0));
        check("R8 strobe count", strobes, m_strobes);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mode", int'(mode), 0);
        check("R1 valid", int'(mode_valid), 0);
        check("R1 change", int'(mode_change), 0);
        check("R1 lost", int'(sig_lost), 0);

        // R5 R3: commit on the fourth agreeing frame, jitter within window
        for (int k = 0; k < 4; k++) frame(3539 + int'($urandom % 7) - 3, "R5 mode1 run");
        check("R3 code 30:12", int'(mode), 1);
        // R8: reconfirming frames give no extra strobe
        for (int k = 0; k < 2; k++) frame(3539, "R8 reconfirm");
        check("R8 single strobe", strobes, 1);
        // R7 R4: stable illegal length is refused
        for (int k = 0; k < 5; k++) frame(3400, "R7 illegal run");
        check("R7 mode kept", int'(mode), 1);
        // R9 R2: upper window edge, heavy tick gaps, change after four frames
        gap_mod = 2;
        for (int k = 0; k < 3; k++) frame(3201, "R9 before commit");
        check("R9 still old", int'(mode), 1);
        frame(3201, "R9 commit");
        check("R2 R3 code 27:15", int'(mode), 2);
        gap_mod = 16;
        // R4: one past the window
        for (int k = 0; k < 4; k++) frame(3548, "R4 outside");
        check("R4 mode kept", int'(mode), 2);
        // R6: same code but lengths 16 apart restart the run
        for (int k = 0; k < 3; k++) frame(2840, "R6 low edge");
        frame(2856, "R6 jump");
        check("R6 no commit", int'(mode), 2);
        for (int k = 0; k < 3; k++) frame(2856, "R6 new run");
        check("R6 code 24:18", int'(mode), 3);
        // R10: silence
        for (int i = 0; i < 19900; i++) begin
            env_bit = 1'b0; us_tick = 1'b1; @(negedge clk);
        end
        check("R10 not yet lost", int'(sig_lost), 0);
        for (int i = 0; i < 110; i++) begin
            env_bit = 1'b0; us_tick = 1'b1; @(negedge clk);
        end
        check("R10 lost", int'(sig_lost), 1);
        check("R10 mode cleared", int'(mode), 0);
        check("R10 valid cleared", int'(mode_valid), 0);
        m_mode = 0; m_prev_vld = 0; m_cand = 0; m_agree = 0;
        frame(3193, "R10 first frame");
        check("R10 lost cleared", int'(sig_lost), 0);
        // random runs
        for (int g = 0; g < 2; g++) begin
            int base;
            case ($urandom % 3)
                0: base = 3539;
                1: base = 3193;
                default: base = 2848;
            endcase
            for (int k = 0; k < 4; k++) frame(base + int'($urandom % 7) - 3, "R5 random run");
        end
        done = 1;
        report();
    end
endmodule